// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers up to 32 level-sensitive interrupt requests from peripherals and steers each one onto one of nine prioritized general-purpose interrupt lines. Those lines feed the core's event controller, which ranks them by priority. Every source owns a 4-bit routing field. Software can rewrite each field over a simple word-addressed register bus, so any request can reach any line. Out of reset a fixed default map applies, with source n driving line n mod 9.

The request lines are sampled into a status register on every clock. A per-source enable register gates which sampled requests reach the lines. A separate per-source wake-enable register selects which pending requests raise the wakeup output, and it does so whatever the enable bits hold. Each general-purpose line is the OR of all pending, enabled sources routed to it.

Register map (word addresses on `bus_addr_i`):

| Address | Register |
|---|---|
| 0 | enable |
| 1 | status, read-only |
| 2 | wake-enable |
| 3 | unmapped |
| 4 to 7 | routing words |

Within a routing word, source 8*w+j sits in bits [4j+3:4j] of word 4+w.

Top module: `irq_route_ctrl`

## Requirements
- R1: The status register captures `src_req_i` at every rising clock edge. A read at address 1 returns the value captured at the latest edge.
- R2: After reset the enable and wake-enable registers read 0, and routing field n holds n mod 9. Routing words 4 to 7 therefore read 0x76543210, 0x65432108, 0x54321087 and 0x43210876. All outputs are low.
- R3: Line k of `gp_irq_o` is high exactly when at least one source with routing field k is set in status and has its enable bit at 1.
- R4: A routing field holding a value from 9 to 15 connects its source to no line.
- R5: `wake_o` is high exactly when some source is set in status and also has its wake-enable bit at 1, whatever its enable bit holds.
- R6: A bus write to address 0, 2 or 4 to 7 takes effect at the clock edge that samples it. Before that edge the old contents still read back and still steer the outputs. After the edge the written value reads back.
- R7: Writes to address 1 and address 3 change no register. Address 3 reads as 0.
- R8: Several sources routed to one line combine by OR. Disabling one of them leaves the line high while another enabled source on it is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 32 | Level requests, one per peripheral source |
| bus_addr_i | input | 3 | Register word address, used for both read and write |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| gp_irq_o | output | 9 | General-purpose interrupt lines toward the event controller |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench builds the block with its default parameters: 32 sources, 9 lines and 4-bit routing fields. With this build the default map wraps around the nine lines more than three times, so two or more sources share each line. The spare field codes 9 to 15 can also be written, which makes the ignored-route case reachable. Checking all four routing words against their reset values exercises the field packing at every nibble position. Writing a field at the top of the range exercises the highest line.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_WAKE   = 3'd2;
    localparam int unsigned       A_ROUTE_BASE = 4;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_OUT = 9,
    parameter int unsigned FIELD_W = 4
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [NUM_SRC-1:0]                src_req_i,
    input  logic [ADDR_W-1:0]                 bus_addr_i,
    input  logic                              bus_wr_i,
    input  logic [WORD_W-1:0]                 bus_wdata_i,
    output logic [WORD_W-1:0]                 bus_rdata_o,
    output logic [NUM_SRC-1:0]                enable_o,
    output logic [NUM_SRC-1:0]                wake_en_o,
    output logic [NUM_SRC-1:0]                status_o,
    output logic [NUM_SRC-1:0][FIELD_W-1:0]   route_o
);

    localparam int unsigned FPW = WORD_W / FIELD_W;

    typedef logic [NUM_SRC-1:0][FIELD_W-1:0] route_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] wake_en;
        logic [NUM_SRC-1:0] status;
        route_t             route;
    } state_t;

    function automatic route_t default_route();
        route_t r;
        for (int n = 0; n < int'(NUM_SRC); n++) begin
            r[n] = FIELD_W'(n % int'(NUM_OUT));
        end
        return r;
    endfunction

    localparam state_t RESET_STATE = '{
        enable:  '0,
        wake_en: '0,
        status:  '0,
        route:   default_route()
    };

    state_t st_d, st_q;

    // Next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.status = src_req_i;
        if (bus_wr_i) begin
            if (bus_addr_i == A_ENABLE) begin
                st_d.enable = bus_wdata_i[NUM_SRC-1:0];
            end
            if (bus_addr_i == A_WAKE) begin
                st_d.wake_en = bus_wdata_i[NUM_SRC-1:0];
            end
            for (int n = 0; n < int'(NUM_SRC); n++) begin
                if (int'(bus_addr_i) == int'(A_ROUTE_BASE) + n / int'(FPW)) begin
                    st_d.route[n] = bus_wdata_i[(n % int'(FPW))*int'(FIELD_W) +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_ENABLE) begin
            bus_rdata_o[NUM_SRC-1:0] = st_q.enable;
        end else if (bus_addr_i == A_STATUS) begin
            bus_rdata_o[NUM_SRC-1:0] = st_q.status;
        end else if (bus_addr_i == A_WAKE) begin
            bus_rdata_o[NUM_SRC-1:0] = st_q.wake_en;
        end else begin
            for (int n = 0; n < int'(NUM_SRC); n++) begin
                if (int'(bus_addr_i) == int'(A_ROUTE_BASE) + n / int'(FPW)) begin
                    bus_rdata_o[(n % int'(FPW))*int'(FIELD_W) +: FIELD_W] = st_q.route[n];
                end
            end
        end
    end

    assign enable_o  = st_q.enable;
    assign wake_en_o = st_q.wake_en;
    assign status_o  = st_q.status;
    assign route_o   = st_q.route;

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_OUT = 9,
    parameter int unsigned FIELD_W = 4
) (
    input  logic [NUM_SRC-1:0]              status_i,
    input  logic [NUM_SRC-1:0]              enable_i,
    input  logic [NUM_SRC-1:0]              wake_en_i,
    input  logic [NUM_SRC-1:0][FIELD_W-1:0] route_i,
    output logic [NUM_OUT-1:0]              gp_irq_o,
    output logic                            wake_o
);

    logic [NUM_SRC-1:0] live;
    assign live = status_i & enable_i;

    for (genvar k = 0; k < int'(NUM_OUT); k++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int n = 0; n < int'(NUM_SRC); n++) begin
                if (live[n] && (route_i[n] == FIELD_W'(k))) begin
                    hit = 1'b1;
                end
            end
        end
        assign gp_irq_o[k] = hit;
    end

    assign wake_o = |(status_i & wake_en_i);

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_OUT = 9,
    parameter int unsigned FIELD_W = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC-1:0]   src_req_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    output logic [NUM_OUT-1:0]   gp_irq_o,
    output logic                 wake_o
);

    logic [NUM_SRC-1:0]              enable;
    logic [NUM_SRC-1:0]              wake_en;
    logic [NUM_SRC-1:0]              status;
    logic [NUM_SRC-1:0][FIELD_W-1:0] route;

    irq_route_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_OUT (NUM_OUT),
        .FIELD_W (FIELD_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_req_i   (src_req_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .enable_o    (enable),
        .wake_en_o   (wake_en),
        .status_o    (status),
        .route_o     (route)
    );

    irq_route_matrix #(
        .NUM_SRC (NUM_SRC),
        .NUM_OUT (NUM_OUT),
        .FIELD_W (FIELD_W)
    ) u_matrix (
        .status_i  (status),
        .enable_i  (enable),
        .wake_en_i (wake_en),
        .route_i   (route),
        .gp_irq_o  (gp_irq_o),
        .wake_o    (wake_o)
    );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_OUT = 9,
    parameter int unsigned FIELD_W = 4
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_SRC-1:0]   src_req_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic                 bus_wr_i,
    input logic [WORD_W-1:0]    bus_wdata_i,
    input logic [WORD_W-1:0]    bus_rdata_o,
    input logic [NUM_OUT-1:0]   gp_irq_o,
    input logic                 wake_o
);

    // Set once a full clock cycle has passed since reset was released
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    p_status_sample_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && bus_addr_i == A_STATUS) |-> (bus_rdata_o == WORD_W'($past(src_req_i))));

    p_quiet_lines_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(src_req_i) == '0) |-> (gp_irq_o == '0));

    p_line_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> ($countones(gp_irq_o) <= $countones($past(src_req_i))));

    p_quiet_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(src_req_i) == '0) |-> !wake_o);

    p_enable_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_ENABLE) |=>
            (bus_addr_i != A_ENABLE || bus_rdata_o == $past(bus_wdata_i)));

    p_wake_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_WAKE) |=>
            (bus_addr_i != A_WAKE || bus_rdata_o == $past(bus_wdata_i)));

    p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == 3'd3) |-> (bus_rdata_o == '0));

endmodule

bind irq_route_ctrl irq_route_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_OUT (NUM_OUT),
    .FIELD_W (FIELD_W)
) u_chk (.*);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] src_req_i = '0;
    logic [2:0]  bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [8:0]  gp_irq_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk_i = ~clk_i;

    irq_route_ctrl u0 (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_req_i   (src_req_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .gp_irq_o    (gp_irq_o),
        .wake_o      (wake_o)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] wk_en;
        logic [31:0] req;
        logic [8:0]  exp_irq;
        logic        exp_wake;
    } vec_t;

    // Default routing: source n drives line n mod 9
    localparam vec_t VECS [10] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 9'h001, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0200, 9'h001, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0100, 9'h100, 1'b0},
        '{32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 9'h000, 1'b1},
        '{32'h0000_000F, 32'h0000_0000, 32'h0000_00FF, 9'h00F, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000, 9'h010, 1'b0},
        '{32'hFFFF_FFFF, 32'h0001_0000, 32'h0002_0000, 9'h100, 1'b0},
        '{32'hFFFF_0000, 32'h0000_0000, 32'h0000_FFFF, 9'h000, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 9'h1FF, 1'b0},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0040_0000, 9'h000, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk_i);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_wr_i    = 1'b1;
        @(negedge clk_i);
        bus_wr_i    = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk_i);
        bus_addr_i = a;
        #0.5;
        d = bus_rdata_o;
    endtask

    task automatic drive_req(input logic [31:0] v);
        @(negedge clk_i);
        src_req_i = v;
        @(negedge clk_i);
        #0.5;
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R2 reset state
        rd_reg(3'd0, rd); check("R2 enable reset", rd, 32'h0);
        rd_reg(3'd2, rd); check("R2 wake reset", rd, 32'h0);
        rd_reg(3'd4, rd); check("R2 route0 reset", rd, 32'h7654_3210);
        rd_reg(3'd5, rd); check("R2 route1 reset", rd, 32'h6543_2108);
        rd_reg(3'd6, rd); check("R2 route2 reset", rd, 32'h5432_1087);
        rd_reg(3'd7, rd); check("R2 route3 reset", rd, 32'h4321_0876);
        check("R2 lines reset", {22'h0, wake_o, gp_irq_o}, 32'h0);

        // R3 R5 vector table under default routing
        for (int i = 0; i < 10; i++) begin
            wr_reg(3'd0, VECS[i].en);
            wr_reg(3'd2, VECS[i].wk_en);
            drive_req(VECS[i].req);
            check($sformatf("R3 vector %0d lines", i), {23'h0, gp_irq_o}, {23'h0, VECS[i].exp_irq});
            check($sformatf("R5 vector %0d wake", i), {31'h0, wake_o}, {31'h0, VECS[i].exp_wake});
        end
        wr_reg(3'd2, 32'h0);

        // R1 status sampling timing
        @(negedge clk_i);
        src_req_i  = 32'h0;
        bus_addr_i = 3'd1;
        @(negedge clk_i);
        src_req_i = 32'hA5A5_0003;
        #0.5;
        check("R1 status before edge", bus_rdata_o, 32'h0);
        @(negedge clk_i);
        #0.5;
        check("R1 status after edge", bus_rdata_o, 32'hA5A5_0003);

        // R7 status is read-only, address 3 is inert
        src_req_i = 32'h1234_5678;
        wr_reg(3'd1, 32'h0);
        rd_reg(3'd1, rd); check("R7 status write ignored", rd, 32'h1234_5678);
        wr_reg(3'd0, 32'h0F0F_0F0F);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd3, rd); check("R7 unmapped reads zero", rd, 32'h0);
        rd_reg(3'd0, rd); check("R7 enable untouched", rd, 32'h0F0F_0F0F);
        rd_reg(3'd2, rd); check("R7 wake untouched", rd, 32'h0);

        // R4 out-of-range route codes
        wr_reg(3'd0, 32'hFFFF_FFFF);
        drive_req(32'h0000_0001);
        wr_reg(3'd4, 32'h7654_3219);
        #0.5;
        check("R4 code 9 drives nothing", {23'h0, gp_irq_o}, 32'h0);
        wr_reg(3'd4, 32'h7654_321F);
        #0.5;
        check("R4 code 15 drives nothing", {23'h0, gp_irq_o}, 32'h0);

        // R6 write timing on a route field
        @(negedge clk_i);
        bus_addr_i  = 3'd4;
        bus_wdata_i = 32'h7654_3218;
        bus_wr_i    = 1'b1;
        #0.5;
        check("R6 route old before edge", bus_rdata_o, 32'h7654_321F);
        check("R6 lines old before edge", {23'h0, gp_irq_o}, 32'h0);
        @(negedge clk_i);
        bus_wr_i = 1'b0;
        #0.5;
        check("R6 route new after edge", bus_rdata_o, 32'h7654_3218);
        check("R6 line 8 after edge", {23'h0, gp_irq_o}, 32'h100);

        // R8 shared line OR
        wr_reg(3'd4, 32'h7654_3210);
        drive_req(32'h0000_0201);
        check("R8 two sources on line 0", {23'h0, gp_irq_o}, 32'h001);
        wr_reg(3'd0, 32'hFFFF_FFFE);
        #0.5;
        check("R8 one disabled, line held", {23'h0, gp_irq_o}, 32'h001);
        wr_reg(3'd0, 32'hFFFF_FDFE);
        #0.5;
        check("R8 both disabled", {23'h0, gp_irq_o}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule